// File: doc/BRIEF.md
# Bitplane fetch window sequencer

This block times bitplane DMA for one scanline. It watches a horizontal colour-clock position supplied by the beam counter, together with programmable fetch-window start and stop positions. From these it produces fetch units of eight colour clocks each. For every clock inside a unit it raises at most one plane strobe, which tells the memory side which bitplane owns that bus slot. It pulses a unit-start marker at the first clock of each unit and a row-done marker once the row has finished. A running count of words per plane accumulates across the row.

The window positions pass through a comparator mask that depends on a chip-revision select, so older parts see the window on a coarser grid. The stop position does not cut a row short. The row always runs through the first unit that begins at or after the masked stop, so a stop that falls inside a unit lengthens the row by one unit. The plane count is captured when each unit opens. Changing it part-way through a row therefore only affects the units that start afterwards.

Each output reflects the colour clock that `hpos` held at the previous rising edge. Outputs are registered, so they lag the counter by one cycle.

Top module: `bpf_fetch_seq`

## Requirements
- R1: The start and stop positions are masked before comparison: with `rev_new`=0 the two least significant bits are cleared (4-clock grid); with `rev_new`=1 only bit 0 is cleared (2-clock grid).
- R2: Units are 8 colour clocks long. The first unit begins at the masked start, and each later unit begins 8 clocks after the one before. `unit_start` is high during the cycle that shows the first clock of each unit, one cycle after the edge at which `hpos` equalled that position.
- R3: The last unit of a row is the first one whose start position is at or after the masked stop. If the masked stop is at or before the masked start, the row has exactly one unit.
- R4: `row_words` is cleared at line start. It rises by 1 for each lo-res unit and by 2 for each hi-res unit, and already includes a unit in that unit's `unit_start` cycle. In lo-res with the older revision, 0x34/0xD4 gives 21, 0x28/0xD4 gives 23 and 0x4A/0xB6 gives 15. In hi-res, 0x64/0xA8 gives 20.
- R5: `plane_cnt` and `hires` are captured when a unit opens and hold for that whole unit, so a change in the middle of a row affects only units that start later.
- R6: Lo-res slot table. Offsets 0 to 7 within the unit serve planes 4, 6, 2, idle, 3, 5, 1, idle. `plane_stb` bit k stands for plane k+1.
- R7: Hi-res slot table. Offsets 0 to 7 serve planes 4, 2, 3, 1, 4, 2, 3, 1.
- R8: A slot for plane p strobes only when p is no greater than the captured plane count; otherwise the slot stays idle. At most one `plane_stb` bit is high in any cycle.
- R9: `row_done` is a one-cycle pulse in the cycle after the last unit's offset-7 slot, which is the position masked start + 8 × units.
- R10: Reset and a `line_start` cycle clear all unit state. In the following cycle `unit_start`, `row_done`, `plane_stb` and `row_words` are all zero, even if the previous row was still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour-clock rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Synchronous clear at the beginning of a scanline |
| hpos | input | HW | Horizontal colour-clock position |
| ddf_start | input | DW | Fetch window start position, unmasked |
| ddf_stop | input | DW | Fetch window stop position, unmasked |
| hires | input | 1 | 1 = hi-res (two words per plane per unit) |
| rev_new | input | 1 | 1 = newer revision with 2-clock comparator precision |
| plane_cnt | input | PCW | Number of enabled bitplanes |
| unit_start | output | 1 | First clock of a fetch unit |
| plane_stb | output | NPL | One-hot plane fetch strobe for the current slot |
| row_done | output | 1 | Pulse one clock after the last unit's final slot |
| row_words | output | WW | Words per plane fetched so far in this row |

## Verification
The bench builds the block with its default parameters: a 9-bit position, 8-bit window registers, eight plane strobes and an 8-bit word count. With these values, a 240-clock line holds every window the sweep produces, including the widest 25-unit row.

The sweep covers start positions from 0x18 to 0x60, stop positions from 0x90 to 0xD8, both revisions, both resolutions and every plane count from 0 to 8. For each clock of each line it compares `unit_start`, `row_done`, the strobe vector and the running word count against arithmetic worked out in the bench.

Directed lines then cover the four documented word counts, a stop placed before the start, a plane-count drop in mid-row, and a row that is cut off by a new line start.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  localparam int unsigned UNIT_CLKS = 8;
  localparam int unsigned OFF_W = $clog2(UNIT_CLKS);

  typedef struct packed {
    logic       vld;
    logic [2:0] idx;
  } slot_t;

  // Plane owning a slot at a given offset inside a unit (idx is plane-1).
  function automatic slot_t slot_of(input logic [OFF_W-1:0] off, input logic hr);
    slot_t s;
    s.vld = 1'b1;
    s.idx = 3'd0;
    if (hr) begin
      case (off[1:0])
        2'd0: s.idx = 3'd3;
        2'd1: s.idx = 3'd1;
        2'd2: s.idx = 3'd2;
        default: s.idx = 3'd0;
      endcase
    end else begin
      case (off)
        3'd0: s.idx = 3'd3;
        3'd1: s.idx = 3'd5;
        3'd2: s.idx = 3'd1;
        3'd4: s.idx = 3'd2;
        3'd5: s.idx = 3'd4;
        3'd6: s.idx = 3'd0;
        default: s.vld = 1'b0;
      endcase
    end
    return s;
  endfunction

  // Words per plane that one unit contributes.
  function automatic logic [1:0] unit_words(input logic hr);
    return hr ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/bpf_ddf_mask.sv
module bpf_ddf_mask #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] raw,
  input  logic          rev_new,
  output logic [DW-1:0] masked
);
  localparam logic [DW-1:0] FINE_DROP   = DW'(1);
  localparam logic [DW-1:0] COARSE_DROP = DW'(3);

  always_comb begin
    masked = raw & ~(rev_new ? FINE_DROP : COARSE_DROP);
  end
endmodule

// File: rtl/bpf_slot_decode.sv
module bpf_slot_decode
  import bpf_pkg::*;
#(
  parameter int NPL = 8,
  parameter int PCW = 4
) (
  input  logic             run,
  input  logic [OFF_W-1:0] off,
  input  logic             hr,
  input  logic [PCW-1:0]   pl,
  output logic [NPL-1:0]   stb
);
  slot_t cur;
  assign cur = slot_of(off, hr);

  for (genvar k = 0; k < NPL; k++) begin : g_stb
    assign stb[k] = run && cur.vld && (32'(cur.idx) == k) && (32'(pl) > k);
  end
endmodule

// File: rtl/bpf_word_count.sv
module bpf_word_count
  import bpf_pkg::*;
#(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          hr,
  output logic [WW-1:0] words
);
  localparam logic [WW:0] TOP = {1'b0, {WW{1'b1}}};
  logic [WW:0] sum;

  assign sum = {1'b0, words} + (WW+1)'(unit_words(hr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      words <= '0;
    else if (clr)    words <= '0;
    else if (inc)    words <= (sum > TOP) ? TOP[WW-1:0] : sum[WW-1:0];
  end
endmodule

// File: rtl/bpf_unit_seq.sv
module bpf_unit_seq
  import bpf_pkg::*;
#(
  parameter int HW  = 9,
  parameter int DW  = 8,
  parameter int PCW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [HW-1:0]    hpos,
  input  logic [DW-1:0]    start_m,
  input  logic [DW-1:0]    stop_m,
  input  logic [PCW-1:0]   plane_cnt,
  input  logic             hires,
  output logic             unit_go,
  output logic             run,
  output logic [OFF_W-1:0] off,
  output logic [PCW-1:0]   pl_lat,
  output logic             hr_lat,
  output logic             done
);
  localparam logic [OFF_W-1:0] TAIL = OFF_W'(UNIT_CLKS - 1);

  logic last_q, fin_q;
  logic at_start, stop_hit, at_tail, row_end;

  assign at_start = (hpos == HW'(start_m));
  assign stop_hit = (hpos >= HW'(stop_m));
  assign at_tail  = run && (off == TAIL);
  assign unit_go  = (!run && !fin_q && at_start) || (at_tail && !last_q);
  assign row_end  = at_tail && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      off    <= '0;
      last_q <= 1'b0;
      fin_q  <= 1'b0;
      pl_lat <= '0;
      hr_lat <= 1'b0;
      done   <= 1'b0;
    end else if (line_start) begin
      run    <= 1'b0;
      off    <= '0;
      last_q <= 1'b0;
      fin_q  <= 1'b0;
      pl_lat <= '0;
      hr_lat <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= row_end;
      if (unit_go) begin
        run    <= 1'b1;
        off    <= '0;
        last_q <= stop_hit;
        pl_lat <= plane_cnt;
        hr_lat <= hires;
      end else if (row_end) begin
        run   <= 1'b0;
        off   <= '0;
        fin_q <= 1'b1;
      end else if (run) begin
        off <= off + OFF_W'(1);
      end
    end
  end
endmodule

// File: rtl/bpf_fetch_seq.sv
module bpf_fetch_seq
  import bpf_pkg::*;
#(
  parameter int HW  = 9,
  parameter int DW  = 8,
  parameter int NPL = 8,
  parameter int PCW = $clog2(NPL + 1),
  parameter int WW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_start,
  input  logic [HW-1:0]  hpos,
  input  logic [DW-1:0]  ddf_start,
  input  logic [DW-1:0]  ddf_stop,
  input  logic           hires,
  input  logic           rev_new,
  input  logic [PCW-1:0] plane_cnt,
  output logic           unit_start,
  output logic [NPL-1:0] plane_stb,
  output logic           row_done,
  output logic [WW-1:0]  row_words
);
  localparam int NREG = 2;

  logic [NREG-1:0][DW-1:0] ddf_raw, ddf_m;
  logic                    unit_go;
  logic                    run;
  logic [OFF_W-1:0]        off;
  logic [PCW-1:0]          pl_lat;
  logic                    hr_lat;

  assign ddf_raw[0] = ddf_start;
  assign ddf_raw[1] = ddf_stop;

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    bpf_ddf_mask #(.DW(DW)) u_mask (
      .raw     (ddf_raw[g]),
      .rev_new (rev_new),
      .masked  (ddf_m[g])
    );
  end

  bpf_unit_seq #(.HW(HW), .DW(DW), .PCW(PCW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .hpos       (hpos),
    .start_m    (ddf_m[0]),
    .stop_m     (ddf_m[1]),
    .plane_cnt  (plane_cnt),
    .hires      (hires),
    .unit_go    (unit_go),
    .run        (run),
    .off        (off),
    .pl_lat     (pl_lat),
    .hr_lat     (hr_lat),
    .done       (row_done)
  );

  bpf_slot_decode #(.NPL(NPL), .PCW(PCW)) u_dec (
    .run (run),
    .off (off),
    .hr  (hr_lat),
    .pl  (pl_lat),
    .stb (plane_stb)
  );

  bpf_word_count #(.WW(WW)) u_words (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (line_start),
    .inc   (unit_go),
    .hr    (hires),
    .words (row_words)
  );

  assign unit_start = run && (off == '0);
endmodule

// File: rtl/bpf_fetch_seq_chk.sv
module bpf_fetch_seq_chk #(
  parameter int NPL = 8,
  parameter int PCW = 4,
  parameter int WW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           line_start,
  input logic           unit_start,
  input logic           row_done,
  input logic [NPL-1:0] plane_stb,
  input logic [WW-1:0]  row_words,
  input logic [PCW-1:0] pl_lat
);
  logic [7:0] gap;
  logic       in_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap    <= 8'hFF;
      in_row <= 1'b0;
    end else begin
      if (unit_start)       gap <= 8'd1;
      else if (gap != 8'hFF) gap <= gap + 8'd1;
      if (line_start || row_done) in_row <= 1'b0;
      else if (unit_start)        in_row <= 1'b1;
    end
  end

  // R8: never two planes on one slot
  assert_stb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(plane_stb));

  for (genvar k = 0; k < NPL; k++) begin : g_lim
    // R8: strobe only for planes within the captured count
    assert_stb_below_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      plane_stb[k] |-> (32'(pl_lat) > k));
  end

  // R2: consecutive units of one row are eight clocks apart
  assert_unit_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_start && in_row) |-> (gap == 8'd8));

  // R9: done lands eight clocks after the last unit opened
  assert_done_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> (in_row && gap == 8'd8 && !unit_start));

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> !row_done);

  // R10: line start clears everything visible
  assert_line_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (row_words == '0 && !unit_start && !row_done && plane_stb == '0));

  // R4: word count moves only together with a unit opening
  assert_words_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_start && !$past(line_start)) |-> $stable(row_words));
endmodule

bind bpf_fetch_seq bpf_fetch_seq_chk #(.NPL(NPL), .PCW(PCW), .WW(WW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .unit_start (unit_start),
  .row_done   (row_done),
  .plane_stb  (plane_stb),
  .row_words  (row_words),
  .pl_lat     (pl_lat)
);

// File: tb/bpf_fetch_seq_test.sv
module bpf_fetch_seq_test;
  localparam int HW = 9, DW = 8, NPL = 8, PCW = 4, WW = 8, LINE = 240;
  localparam int NOCHG = 100000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           line_start = 1'b0;
  logic           hires = 1'b0;
  logic           rev_new = 1'b0;
  logic [HW-1:0]  hpos = '0;
  logic [DW-1:0]  ddf_start = 8'hFC;
  logic [DW-1:0]  ddf_stop = 8'hFC;
  logic [PCW-1:0] plane_cnt = '0;
  logic           unit_start, row_done;
  logic [NPL-1:0] plane_stb;
  logic [WW-1:0]  row_words;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bpf_fetch_seq #(.HW(HW), .DW(DW), .NPL(NPL), .PCW(PCW), .WW(WW)) uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .hpos(hpos),
    .ddf_start(ddf_start), .ddf_stop(ddf_stop), .hires(hires), .rev_new(rev_new),
    .plane_cnt(plane_cnt), .unit_start(unit_start), .plane_stb(plane_stb),
    .row_done(row_done), .row_words(row_words)
  );

  // R1: grid rounding written arithmetically
  function automatic int grid(int v, bit nw);
    return nw ? (v / 2) * 2 : (v / 4) * 4;
  endfunction

  // R3: unit count from the drain rule
  function automatic int units_for(int sm, int em);
    if (em <= sm) return 1;
    return (em - sm + 7) / 8 + 1;
  endfunction

  // R6 / R7: plane number (1-based) per offset, 0 = idle
  function automatic int plane_at(int off, bit hr);
    if (hr) begin
      case (off % 4)
        0: return 4;
        1: return 2;
        2: return 3;
        default: return 1;
      endcase
    end
    case (off)
      0: return 4;
      1: return 6;
      2: return 2;
      4: return 3;
      5: return 5;
      6: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic run_line(int st, int sp, bit nw, bit hr, int pca, int pcb,
                          int chg, int len, int want);
    int sm, em, u, lat, wexp;
    sm = grid(st, nw);
    em = grid(sp, nw);
    u = units_for(sm, em);
    lat = 0;
    wexp = 0;
    ddf_start = st[DW-1:0];
    ddf_stop = sp[DW-1:0];
    rev_new = nw;
    hires = hr;
    for (int h = 0; h <= len; h++) begin
      @(negedge clk);
      if (h >= 1) begin
        int p, off, pn;
        bit us_e, dn_e;
        logic [NPL-1:0] stb_e;
        p = h - 1;
        us_e = 1'b0;
        stb_e = '0;
        if (p >= sm && p < sm + 8 * u) begin
          off = (p - sm) % 8;
          if (off == 0) begin
            us_e = 1'b1;
            lat = (p >= chg) ? pcb : pca;   // R5: captured at unit open
            wexp += hr ? 2 : 1;
          end
          pn = plane_at(off, hr);
          if (pn != 0 && pn <= lat) stb_e[pn-1] = 1'b1;  // R8
        end
        dn_e = (p == sm + 8 * u);
        vectors++;
        if (unit_start !== us_e) begin
          miscompares++;
          $display("FAIL R2 pos %0d st %h sp %h: unit_start %b expected %b", p, st, sp, unit_start, us_e);
        end else if (row_done !== dn_e) begin
          miscompares++;
          $display("FAIL R9 R3 pos %0d st %h sp %h: row_done %b expected %b", p, st, sp, row_done, dn_e);
        end else if (plane_stb !== stb_e) begin
          miscompares++;
          $display("FAIL %s R8 R5 pos %0d st %h sp %h: plane_stb %b expected %b",
                   hr ? "R7" : "R6", p, st, sp, plane_stb, stb_e);
        end else if (row_words !== WW'(wexp)) begin
          miscompares++;
          $display("FAIL R4 R10 pos %0d st %h sp %h: row_words %0d expected %0d", p, st, sp, row_words, wexp);
        end
      end
      if (h < len) begin
        hpos = HW'(h);
        line_start = (h == 0);
        plane_cnt = PCW'((h >= chg) ? pcb : pca);
      end
    end
    line_start = 1'b0;
    if (want >= 0) begin
      vectors++;
      if (row_words !== WW'(want)) begin
        miscompares++;
        $display("FAIL R4 st %h sp %h: row_words %0d expected %0d", st, sp, row_words, want);
      end
    end
  endtask

  task automatic check_idle(string tag);
    vectors++;
    if (unit_start !== 1'b0 || row_done !== 1'b0 || plane_stb !== '0 || row_words !== '0) begin
      miscompares++;
      $display("FAIL R10 %s: us %b done %b stb %b words %0d expected all zero",
               tag, unit_start, row_done, plane_stb, row_words);
    end
  endtask

  initial begin
    repeat (200000 - 20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R2 watchdog: run not finished, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    check_idle("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("after reset");

    // R4 R3 R1: documented word counts
    run_line(8'h34, 8'hD4, 1'b0, 1'b0, 6, 6, NOCHG, LINE, 21);
    run_line(8'h28, 8'hD4, 1'b0, 1'b0, 4, 4, NOCHG, LINE, 23);
    run_line(8'h4A, 8'hB6, 1'b0, 1'b0, 5, 5, NOCHG, LINE, 15);
    run_line(8'h64, 8'hA8, 1'b1, 1'b1, 4, 4, NOCHG, LINE, 20);
    // R1: same window, different grid position per revision
    run_line(8'h36, 8'h86, 1'b0, 1'b0, 6, 6, NOCHG, LINE, 11);
    run_line(8'h36, 8'h86, 1'b1, 1'b0, 6, 6, NOCHG, LINE, 11);
    // R3: stop before start gives a single unit
    run_line(8'h90, 8'h40, 1'b1, 1'b0, 3, 3, NOCHG, LINE, 1);
    // R5: plane count drops from 6 to 2 in mid-row
    run_line(8'h38, 8'hC0, 1'b0, 1'b0, 6, 2, 8'h70, LINE, 18);
    // R10: cut a row off, then a fresh line must start clean
    run_line(8'h30, 8'hD0, 1'b0, 1'b1, 4, 4, NOCHG, 8'h70, -1);
    run_line(8'h50, 8'h90, 1'b1, 1'b1, 2, 2, NOCHG, LINE, 18);

    // sweep: windows x revision x resolution x plane count
    for (int st = 8'h18; st <= 8'h60; st += 6) begin
      for (int sp = 8'h90; sp <= 8'hD8; sp += 10) begin
        for (int nw = 0; nw < 2; nw++) begin
          for (int hr = 0; hr < 2; hr++) begin
            int u;
            u = units_for(grid(st, nw[0]), grid(sp, nw[0]));
            run_line(st, sp, nw[0], hr[0], k % 9, k % 9, NOCHG, LINE, u * (hr + 1));
            k++;
          end
        end
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule